// File: doc/BRIEF.md
# Accumulator CPU

This block is a small processor built around one accumulator register. It takes each instruction and each operand from a single memory that is addressed by word. Every instruction is two words long: an opcode word, then an immediate word. The immediate is used as a constant, as a direct address, as the address of a pointer, or as a branch target, depending on the opcode. There are fifteen operations:

- loads and stores, both direct and through a pointer held in memory;
- three kinds of jump;
- add, subtract and NAND, each taking its second operand either from memory or from the immediate;
- a load of the immediate itself.

The processor is not pipelined. It steps through a short sequence of states for each instruction, and each memory read returns its data one cycle after the address is presented. When it meets a halt opcode it stops fetching, holds its state and raises `halted`. A system uses it by placing a program and its data in the attached memory, releasing reset, and watching `halted` and the memory writes.

Top module: `acc_cpu`

## Requirements
- R1: Reset sets the accumulator and the program counter to zero. In the first cycle after reset is released, the block drives `mem_addr` = 0, holds `mem_we` low and holds `halted` low.
- R2: An instruction is an opcode word at the program counter followed by an immediate word at the program counter + 1. The opcode is bits [3:0] of the opcode word; bits [15:4] have no effect. The codes are: 0 halt, 1 direct load, 2 pointer load, 3 direct store, 4 pointer store, 5 jump, 6 jump if zero, 7 jump if nonzero, 8 add memory, 9 subtract memory, 10 NAND memory, 11 add immediate, 12 subtract immediate, 13 NAND immediate, 14 load immediate. When no jump is taken, the program counter advances by 2.
- R3: Opcode 0 raises `halted`. After that, `halted` stays high until reset, no write is issued, and `mem_addr` stays on the address of the halt instruction.
- R4: A direct load sets acc = mem[imm]. A load immediate sets acc = imm.
- R5: A pointer load sets acc = mem[mem[imm]].
- R6: A direct store writes the accumulator to address imm. A pointer store writes it to address mem[imm]. Two writes never occur in consecutive cycles.
- R7: The unconditional jump loads imm into the program counter. Jump-if-zero does so only when acc = 0, and jump-if-nonzero only when acc ≠ 0.
- R8: The memory forms compute acc + m, acc − m and ~(acc & m), where m = mem[imm], and the result wraps modulo 2^16.
- R9: The immediate forms compute the same three results using imm in place of m.
- R10: Opcode 15 behaves exactly like opcode 0.
- R11: Each instruction takes a fixed number of cycles, counted from its opcode fetch: 3 for immediate operations and jumps, 3 for a direct store, 4 for a direct load or a memory-operand operation, 4 for a pointer store, and 5 for a pointer load. A halt raises `halted` 2 cycles after its opcode fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Word address for the current memory read or write |
| mem_wdata | output | 16 | Data to write (the accumulator) |
| mem_we | output | 1 | Write strobe for `mem_addr` |
| mem_rdata | input | 16 | Read data for the address presented in the previous cycle |
| halted | output | 1 | High once a halt opcode has been executed |

## Verification
Two things can coincide here. A store's write may land on the very word that the next opcode fetch reads, and the write and that fetch fall on adjacent edges. The bench provokes this with a store of zero placed directly in front of the instruction it overwrites, so the replaced word must take effect as a halt. A pass is judged by the cycle on which `halted` rises and by the frozen fetch address. In the same way, a taken jump and a fall-through are told apart by which stores the scoreboard sees and by the total cycle count.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_HALT  = 4'd0,
        OP_LD    = 4'd1,
        OP_LDP   = 4'd2,
        OP_ST    = 4'd3,
        OP_STP   = 4'd4,
        OP_JMP   = 4'd5,
        OP_JZ    = 4'd6,
        OP_JNZ   = 4'd7,
        OP_MADD  = 4'd8,
        OP_MSUB  = 4'd9,
        OP_MNAND = 4'd10,
        OP_IADD  = 4'd11,
        OP_ISUB  = 4'd12,
        OP_INAND = 4'd13,
        OP_ILD   = 4'd14,
        OP_XHALT = 4'd15
    } op_e;

    typedef enum logic [2:0] {
        ST_FOP,
        ST_FIMM,
        ST_PTR,
        ST_MEM,
        ST_EXEC,
        ST_HALT
    } state_e;

    function automatic logic op_stops(op_e op);
        return (op == OP_HALT) || (op == OP_XHALT);
    endfunction

    function automatic logic op_via_ptr(op_e op);
        return (op == OP_LDP) || (op == OP_STP);
    endfunction

    function automatic logic op_writes(op_e op);
        return (op == OP_ST) || (op == OP_STP);
    endfunction

    function automatic logic op_touches_mem(op_e op);
        case (op)
            OP_LD, OP_LDP, OP_ST, OP_STP, OP_MADD, OP_MSUB, OP_MNAND: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] result,
    output logic              acc_we
);

    always_comb begin
        result = acc;
        acc_we = 1'b1;
        case (op)
            OP_MADD, OP_IADD:        result = acc + opnd;
            OP_MSUB, OP_ISUB:        result = acc - opnd;
            OP_MNAND, OP_INAND:      result = ~(acc & opnd);
            OP_LD, OP_LDP, OP_ILD:   result = opnd;
            default:                 acc_we = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_cpu_branch.sv
module acc_cpu_branch
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] acc,
    output logic              taken
);

    logic acc_zero;
    assign acc_zero = (acc == '0);

    always_comb begin
        case (op)
            OP_JMP:  taken = 1'b1;
            OP_JZ:   taken = acc_zero;
            OP_JNZ:  taken = !acc_zero;
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);

    localparam logic [ADDR_W-1:0] IMM_OFS = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(2);

    typedef struct packed {
        state_e            st;
        op_e               op;
        logic [DATA_W-1:0] acc;
        logic [ADDR_W-1:0] pc;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic [DATA_W-1:0] alu_res;
    logic              alu_we;
    logic              br_taken;
    logic [ADDR_W-1:0] rd_as_addr;
    op_e               rd_op;
    logic              unused_hi_bits;

    assign rd_as_addr     = mem_rdata[ADDR_W-1:0];
    assign rd_op          = op_e'(mem_rdata[OP_W-1:0]);
    assign unused_hi_bits = ^mem_rdata[DATA_W-1:OP_W];

    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op     (cur_q.op),
        .acc    (cur_q.acc),
        .opnd   (mem_rdata),
        .result (alu_res),
        .acc_we (alu_we)
    );

    acc_cpu_branch #(.DATA_W(DATA_W)) u_branch (
        .op    (cur_q.op),
        .acc   (cur_q.acc),
        .taken (br_taken)
    );

    always_comb begin
        nxt_d     = cur_q;
        mem_addr  = cur_q.pc;
        mem_we    = 1'b0;
        mem_wdata = cur_q.acc;
        case (cur_q.st)
            ST_FOP: begin
                nxt_d.st = ST_FIMM;
            end
            ST_FIMM: begin
                nxt_d.op = rd_op;
                if (op_stops(rd_op)) begin
                    nxt_d.st = ST_HALT;
                end else begin
                    mem_addr = cur_q.pc + IMM_OFS;
                    if (op_via_ptr(rd_op))          nxt_d.st = ST_PTR;
                    else if (op_touches_mem(rd_op)) nxt_d.st = ST_MEM;
                    else                            nxt_d.st = ST_EXEC;
                end
            end
            ST_PTR: begin
                mem_addr = rd_as_addr;
                nxt_d.st = ST_MEM;
            end
            ST_MEM: begin
                mem_addr = rd_as_addr;
                if (op_writes(cur_q.op)) begin
                    mem_we   = 1'b1;
                    nxt_d.pc = cur_q.pc + PC_STEP;
                    nxt_d.st = ST_FOP;
                end else begin
                    nxt_d.st = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (alu_we) nxt_d.acc = alu_res;
                nxt_d.pc = br_taken ? rd_as_addr : cur_q.pc + PC_STEP;
                nxt_d.st = ST_FOP;
            end
            ST_HALT: begin
                nxt_d.st = ST_HALT;
            end
            default: begin
                nxt_d.st = ST_FOP;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{st: ST_FOP, op: OP_HALT, acc: '0, pc: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign halted = (cur_q.st == ST_HALT);

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              halted
);

    p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_addr == '0 && !mem_we && !halted));

    p_halt_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_halt_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);

    p_halt_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(mem_addr));

    p_write_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .halted   (halted)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic        halted;

    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] mem [256];

    int checks = 0;
    int fails  = 0;

    logic [15:0] exp_addr_q[$];
    logic [15:0] exp_data_q[$];
    string       exp_tag_q[$];

    always #5 clk = ~clk;

    acc_cpu u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    always @(posedge clk) begin
        if (ld_en)       mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every write is compared with the next expected item.
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (exp_addr_q.size() == 0) begin
                check(1'b0, "R6", "unexpected write addr", int'(mem_addr), 0);
            end else begin
                logic [15:0] ea;
                logic [15:0] ed;
                string       et;
                ea = exp_addr_q.pop_front();
                ed = exp_data_q.pop_front();
                et = exp_tag_q.pop_front();
                check(mem_addr == ea, et, "write address", int'(mem_addr), int'(ea));
                check(mem_wdata == ed, et, "write data", int'(mem_wdata), int'(ed));
            end
        end
    end

    task automatic expect_write(input logic [15:0] a, input logic [15:0] d, input string tag);
        exp_addr_q.push_back(a);
        exp_data_q.push_back(d);
        exp_tag_q.push_back(tag);
    endtask

    task automatic put(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_addr = a;
        ld_data = d;
        @(posedge clk);
        #1 ld_en = 1'b0;
    endtask

    task automatic ins(input logic [7:0] a, input logic [15:0] opw, input logic [15:0] imm);
        put(a, opw);
        put(a + 8'd1, imm);
    endtask

    task automatic begin_test();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 256; i++) put(i[7:0], 16'h0000);
    endtask

    task automatic run_prog(input int exp_cycles, input logic [15:0] halt_addr);
        int n;
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: state right after reset release
        check(mem_addr == 16'h0, "R1", "first fetch address", int'(mem_addr), 0);
        check(!mem_we && !halted, "R1", "we/halted after reset", int'({mem_we, halted}), 0);
        n = 0;
        while (!halted && n < 400) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            #1;
        end
        check(halted, "R3", "halted raised", int'(halted), 1);
        check(n == exp_cycles, "R11", "cycles to halt", n, exp_cycles);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            #1;
            check(halted && mem_addr == halt_addr, "R3", "frozen after halt",
                  int'(mem_addr), int'(halt_addr));
        end
        check(exp_addr_q.size() == 0, "R6", "writes still expected",
              exp_addr_q.size(), 0);
        exp_addr_q.delete();
        exp_data_q.delete();
        exp_tag_q.delete();
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!halted && !mem_we, "R1", "outputs during reset", int'({halted, mem_we}), 0);

        // Test A: arithmetic, loads, stores, pointer access (R4 R5 R6 R8 R9)
        begin_test();
        ins(8'd0,  16'd14, 16'h1234);  // load immediate
        ins(8'd2,  16'd3,  16'h0080);
        ins(8'd4,  16'd11, 16'hF000);  // add imm, wraps
        ins(8'd6,  16'd3,  16'h0081);
        ins(8'd8,  16'd12, 16'h0235);  // sub imm, wraps
        ins(8'd10, 16'd3,  16'h0082);
        ins(8'd12, 16'd13, 16'h00F0);  // nand imm
        ins(8'd14, 16'd3,  16'h0083);
        ins(8'd16, 16'd1,  16'h0090);  // direct load
        ins(8'd18, 16'd8,  16'h0091);  // add mem
        ins(8'd20, 16'd9,  16'h0092);  // sub mem
        ins(8'd22, 16'd3,  16'h0084);
        ins(8'd24, 16'd10, 16'h0093);  // nand mem
        ins(8'd26, 16'd3,  16'h0085);
        ins(8'd28, 16'd2,  16'h0094);  // pointer load
        ins(8'd30, 16'd4,  16'h0095);  // pointer store
        ins(8'd32, 16'd0,  16'h0000);  // halt
        put(8'h90, 16'h0005);
        put(8'h91, 16'h0003);
        put(8'h92, 16'h000A);
        put(8'h93, 16'h00FF);
        put(8'h94, 16'h0091);
        put(8'h95, 16'h00A0);
        expect_write(16'h0080, 16'h1234, "R4");
        expect_write(16'h0081, 16'h0234, "R9");
        expect_write(16'h0082, 16'hFFFF, "R9");
        expect_write(16'h0083, 16'hFF0F, "R9");
        expect_write(16'h0084, 16'hFFFE, "R8");
        expect_write(16'h0085, 16'hFF01, "R8");
        expect_write(16'h00A0, 16'h0003, "R5");
        run_prog(57, 16'd32);

        // Test B: jumps, ignored upper opcode bits, opcode 15 (R2 R7 R10)
        begin_test();
        ins(8'd0,  16'd14,   16'h0000);
        ins(8'd2,  16'd7,    16'h0040);  // nonzero jump, not taken
        ins(8'd4,  16'd6,    16'h000A);  // zero jump, taken
        ins(8'd6,  16'd3,    16'h00B0);  // skipped store
        ins(8'd8,  16'd0,    16'h0000);
        ins(8'd10, 16'hAB0B, 16'h0007);  // add imm, upper bits set (R2)
        ins(8'd12, 16'd6,    16'h0006);  // zero jump, not taken
        ins(8'd14, 16'd7,    16'h0012);  // nonzero jump, taken
        ins(8'd16, 16'd0,    16'h0000);
        ins(8'd18, 16'd3,    16'h00B1);
        ins(8'd20, 16'd5,    16'h0018);  // unconditional jump
        ins(8'd22, 16'd0,    16'h0000);
        ins(8'd24, 16'h000F, 16'h0000);  // opcode 15 halts (R10)
        expect_write(16'h00B1, 16'h0007, "R7");
        run_prog(26, 16'd24);

        // Test C: store overwrites the next opcode word (R6 R3)
        begin_test();
        ins(8'd0, 16'd14, 16'h0000);
        ins(8'd2, 16'd3,  16'h0004);
        ins(8'd4, 16'd14, 16'h0055);
        ins(8'd6, 16'd3,  16'h00C0);
        ins(8'd8, 16'd0,  16'h0000);
        expect_write(16'h0004, 16'h0000, "R6");
        run_prog(8, 16'd4);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule